// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block gathers interrupt requests from up to 64 device sources into one shared raw request word and hands each processor its own filtered view of it. Every processor owns a 64-bit enable mask. Its pending word is the raw request word ANDed with that mask. Its device interrupt line is asserted whenever any pending bit is set. Devices use two index ports, one to raise a source bit and one to drop it. Both ports can act in the same cycle.

Two further per-processor event flags sit next to the device path. The first is an inter-processor interrupt flag, set and cleared by processor bitvectors. The second is a timer flag, set for every processor by a single tick strobe and cleared by a bitvector. Software reaches the masks and the status words through a simple register port. Writes take one clock and reads are combinational. The register map is laid out from the processor count:

| Address | Content | Access |
|---|---|---|
| c, for 0 ≤ c < NCPU | enable mask of processor c | read/write |
| NCPU + c | pending word of processor c | read only |
| 2·NCPU | raw request word | read only |
| 2·NCPU + 1 | IPI flags in bits [NCPU-1:0] | read only |
| 2·NCPU + 2 | timer flags in bits [NCPU-1:0] | read only |

With the default NCPU = 4, this puts the masks at 0–3, the pending words at 4–7, the raw word at 8, the IPI flags at 9 and the timer flags at 10.

Top module: `irq_router`

## Requirements
- R1: While reset is asserted, and after it is released, every mask, raw request, IPI and timer bit reads zero, and every interrupt output is low.
- R2: A pulse on `dev_post` sets raw request bit `dev_post_idx` (0 to 63) at the next rising edge. The raw word is readable at address 2·NCPU.
- R3: A pulse on `dev_clr` resets raw request bit `dev_clr_idx` at the next edge. If a post and a clear name the same index in the same cycle, the bit ends up set. If they name different indices, both take effect.
- R4: A write to address c (c < NCPU) stores all 64 data bits as the mask of processor c. The mask reads back unchanged and governs that processor's outputs from the next cycle on.
- R5: Address NCPU+c reads the raw word ANDed with mask c. `dev_irq[c]` is high exactly when that word is nonzero.
- R6: Each set bit of `ipi_req` sets the matching processor's IPI flag at the next edge. `ipi_irq` presents the flags, and address 2·NCPU+1 returns them in bits [NCPU-1:0] with all higher bits zero.
- R7: Each set bit of `ipi_clr` resets the matching IPI flag. A request and a clear for the same processor in the same cycle leave the flag set.
- R8: A `timer_tick` pulse sets the timer flag of every processor. Each set bit of `tmr_clr` resets one flag, and a tick wins over a clear in the same cycle. `tmr_irq` presents the flags, and address 2·NCPU+2 returns them in the low NCPU bits.
- R9: A write to a read-only or unmapped address changes no state. A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| dev_post | input | 1 | raise the source bit named by dev_post_idx |
| dev_post_idx | input | 6 | source index to raise |
| dev_clr | input | 1 | drop the source bit named by dev_clr_idx |
| dev_clr_idx | input | 6 | source index to drop |
| timer_tick | input | 1 | timer event for all processors |
| ipi_req | input | NCPU | processors to receive an IPI |
| ipi_clr | input | NCPU | processors whose IPI flag is cleared |
| tmr_clr | input | NCPU | processors whose timer flag is cleared |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | ADDR_W | register address |
| reg_wdata | input | 64 | register write data |
| reg_rdata | output | 64 | combinational read data |
| dev_irq | output | NCPU | per-processor device interrupt |
| ipi_irq | output | NCPU | per-processor IPI flag |
| tmr_irq | output | NCPU | per-processor timer flag |

## Verification
The bench drives a post and a clear at the same index in one cycle. A design that let the clear win would lose the request. It also raises the extreme indices 0 and 63, where a truncated or off-by-one index decode would hit the wrong bit or none. It repeats the same-cycle collision test for IPI request against clear and for tick against timer clear. It writes to the raw, pending, status and unmapped addresses, which exposes a decoder that aliases those addresses onto a mask. Random traffic on all ports runs against a bench model, with every pending word read back, so that a mask routed to the wrong processor or applied a cycle late shows up as a mismatch.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int IDX_W = 6;
  localparam int SRC_W = 1 << IDX_W;

  function automatic int addr_span(input int ncpu);
    return 2 * ncpu + 3;
  endfunction

  function automatic int addr_raw(input int ncpu);
    return 2 * ncpu;
  endfunction

  function automatic int addr_ipi(input int ncpu);
    return 2 * ncpu + 1;
  endfunction

  function automatic int addr_tmr(input int ncpu);
    return 2 * ncpu + 2;
  endfunction
endpackage

// File: rtl/irq_reset_sync.sv
module irq_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/irq_raw_req.sv
module irq_raw_req #(
  parameter int IDX_W = 6,
  localparam int SRC_W = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post,
  input  logic [IDX_W-1:0] post_idx,
  input  logic             clr,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [SRC_W-1:0] raw_q
);
  logic [SRC_W-1:0] raw_d;
  logic             raw_en;

  // clear applied first so a post on the same index wins
  always_comb begin
    raw_d  = raw_q;
    raw_en = post | clr;
    if (clr)  raw_d[clr_idx]  = 1'b0;
    if (post) raw_d[post_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end
endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank #(
  parameter int NCPU   = 4,
  parameter int SRC_W  = 64,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [SRC_W-1:0]               wr_data,
  input  logic [SRC_W-1:0]               raw_q,
  output logic [NCPU-1:0][SRC_W-1:0]     mask_q,
  output logic [NCPU-1:0][SRC_W-1:0]     pend,
  output logic [NCPU-1:0]                dev_irq
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic             sel;
    logic [SRC_W-1:0] mask_r;
    logic [SRC_W-1:0] mask_d;

    always_comb begin
      sel    = wr_en && (wr_addr == ADDR_W'(c));
      mask_d = sel ? wr_data : mask_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask_r <= '0;
      else if (sel) mask_r <= mask_d;
    end

    assign mask_q[c]  = mask_r;
    assign pend[c]    = raw_q & mask_r;
    assign dev_irq[c] = |pend[c];
  end
endmodule

// File: rtl/irq_flag_vec.sv
module irq_flag_vec #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] set,
  input  logic [NCPU-1:0] clr,
  output logic [NCPU-1:0] flag_q
);
  logic [NCPU-1:0] flag_d;
  logic            flag_en;

  always_comb begin
    flag_d  = (flag_q & ~clr) | set;
    flag_en = |(set | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read #(
  parameter int NCPU   = 4,
  parameter int SRC_W  = 64,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NCPU-1:0][SRC_W-1:0] mask_q,
  input  logic [NCPU-1:0][SRC_W-1:0] pend,
  input  logic [SRC_W-1:0]           raw_q,
  input  logic [NCPU-1:0]            ipi_q,
  input  logic [NCPU-1:0]            tmr_q,
  output logic [SRC_W-1:0]           rdata
);
  import irq_route_pkg::*;

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (addr == ADDR_W'(c))        rdata = mask_q[c];
      if (addr == ADDR_W'(NCPU + c)) rdata = pend[c];
    end
    if (addr == ADDR_W'(addr_raw(NCPU))) rdata = raw_q;
    if (addr == ADDR_W'(addr_ipi(NCPU))) rdata[NCPU-1:0] = ipi_q;
    if (addr == ADDR_W'(addr_tmr(NCPU))) rdata[NCPU-1:0] = tmr_q;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
#(
  parameter int NCPU    = 4,
  localparam int ADDR_W = $clog2(addr_span(NCPU))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_post,
  input  logic [IDX_W-1:0]  dev_post_idx,
  input  logic              dev_clr,
  input  logic [IDX_W-1:0]  dev_clr_idx,
  input  logic              timer_tick,
  input  logic [NCPU-1:0]   ipi_req,
  input  logic [NCPU-1:0]   ipi_clr,
  input  logic [NCPU-1:0]   tmr_clr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [SRC_W-1:0]  reg_wdata,
  output logic [SRC_W-1:0]  reg_rdata,
  output logic [NCPU-1:0]   dev_irq,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq
);
  logic                          rst_core_n;
  logic [SRC_W-1:0]              raw_q;
  logic [NCPU-1:0][SRC_W-1:0]    mask_q;
  logic [NCPU-1:0][SRC_W-1:0]    pend;

  irq_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  irq_raw_req #(.IDX_W(IDX_W)) u_raw (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .post     (dev_post),
    .post_idx (dev_post_idx),
    .clr      (dev_clr),
    .clr_idx  (dev_clr_idx),
    .raw_q    (raw_q)
  );

  irq_cpu_bank #(.NCPU(NCPU), .SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .pend    (pend),
    .dev_irq (dev_irq)
  );

  irq_flag_vec #(.NCPU(NCPU)) u_ipi (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .set    (ipi_req),
    .clr    (ipi_clr),
    .flag_q (ipi_irq)
  );

  irq_flag_vec #(.NCPU(NCPU)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .set    ({NCPU{timer_tick}}),
    .clr    (tmr_clr),
    .flag_q (tmr_irq)
  );

  irq_reg_read #(.NCPU(NCPU), .SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_rd (
    .addr   (reg_addr),
    .mask_q (mask_q),
    .pend   (pend),
    .raw_q  (raw_q),
    .ipi_q  (ipi_irq),
    .tmr_q  (tmr_irq),
    .rdata  (reg_rdata)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_route_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       dev_post,
  input logic [IDX_W-1:0]           dev_post_idx,
  input logic                       dev_clr,
  input logic [IDX_W-1:0]           dev_clr_idx,
  input logic                       timer_tick,
  input logic [NCPU-1:0]            ipi_req,
  input logic [NCPU-1:0]            ipi_clr,
  input logic [NCPU-1:0]            tmr_clr,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [SRC_W-1:0]           reg_wdata,
  input logic [SRC_W-1:0]           raw_q,
  input logic [NCPU-1:0][SRC_W-1:0] mask_q,
  input logic [NCPU-1:0]            dev_irq,
  input logic [NCPU-1:0]            ipi_irq,
  input logic [NCPU-1:0]            tmr_irq
);
  assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_post |=> raw_q[$past(dev_post_idx)]);

  assert_clear_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clr && !(dev_post && dev_post_idx == dev_clr_idx)) |=> !raw_q[$past(dev_clr_idx)]);

  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr < ADDR_W'(NCPU)) |=> mask_q[$past(reg_addr)] == $past(reg_wdata));

  assert_no_raw_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q == '0) |-> (dev_irq == '0));

  assert_ipi_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_req != '0) |=> ((ipi_irq & $past(ipi_req)) == $past(ipi_req)));

  assert_ipi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_clr & ~ipi_req) != '0) |=> ((ipi_irq & $past(ipi_clr & ~ipi_req)) == '0));

  assert_tick_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_tick |=> (tmr_irq == '1));

  assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr >= ADDR_W'(NCPU)) |=> $stable(mask_q));
endmodule

bind irq_router irq_router_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .dev_post     (dev_post),
  .dev_post_idx (dev_post_idx),
  .dev_clr      (dev_clr),
  .dev_clr_idx  (dev_clr_idx),
  .timer_tick   (timer_tick),
  .ipi_req      (ipi_req),
  .ipi_clr      (ipi_clr),
  .tmr_clr      (tmr_clr),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .raw_q        (raw_q),
  .mask_q       (mask_q),
  .dev_irq      (dev_irq),
  .ipi_irq      (ipi_irq),
  .tmr_irq      (tmr_irq)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int NCPU   = 4;
  localparam int ADDR_W = 4;
  localparam int A_RAW  = 2 * NCPU;
  localparam int A_IPI  = 2 * NCPU + 1;
  localparam int A_TMR  = 2 * NCPU + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dev_post, dev_clr, timer_tick, reg_wr;
  logic [5:0]        dev_post_idx, dev_clr_idx;
  logic [NCPU-1:0]   ipi_req, ipi_clr, tmr_clr;
  logic [ADDR_W-1:0] reg_addr;
  logic [63:0]       reg_wdata, reg_rdata;
  logic [NCPU-1:0]   dev_irq, ipi_irq, tmr_irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [63:0]     raw_m;
  logic [63:0]     mask_m [NCPU];
  logic [NCPU-1:0] ipi_m, tmr_m;

  always #2 clk = ~clk;

  irq_router #(.NCPU(NCPU)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .dev_post(dev_post), .dev_post_idx(dev_post_idx),
    .dev_clr(dev_clr), .dev_clr_idx(dev_clr_idx),
    .timer_tick(timer_tick), .ipi_req(ipi_req), .ipi_clr(ipi_clr), .tmr_clr(tmr_clr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_irq(dev_irq), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  function automatic logic [63:0] exp_read(input int a);
    if (a < NCPU)       return mask_m[a];
    if (a < 2 * NCPU)   return raw_m & mask_m[a - NCPU];
    if (a == A_RAW)     return raw_m;
    if (a == A_IPI)     return {{(64-NCPU){1'b0}}, ipi_m};
    if (a == A_TMR)     return {{(64-NCPU){1'b0}}, tmr_m};
    return 64'd0;
  endfunction

  function automatic logic [NCPU-1:0] exp_dev();
    logic [NCPU-1:0] v;
    for (int c = 0; c < NCPU; c++) v[c] = |(raw_m & mask_m[c]);
    return v;
  endfunction

  task automatic idle();
    dev_post = 0; dev_clr = 0; timer_tick = 0; reg_wr = 0;
    dev_post_idx = '0; dev_clr_idx = '0;
    ipi_req = '0; ipi_clr = '0; tmr_clr = '0;
    reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic model_step();
    if (dev_clr)  raw_m[dev_clr_idx]  = 1'b0;
    if (dev_post) raw_m[dev_post_idx] = 1'b1;
    if (reg_wr && int'(reg_addr) < NCPU) mask_m[int'(reg_addr)] = reg_wdata;
    ipi_m = (ipi_m & ~ipi_clr) | ipi_req;
    tmr_m = (tmr_m & ~tmr_clr) | {NCPU{timer_tick}};
  endtask

  task automatic check_out(input string req);
    checks++;
    if (dev_irq !== exp_dev() || ipi_irq !== ipi_m || tmr_irq !== tmr_m) begin
      errors++;
      $display("FAIL %s outputs dev/ipi/tmr act=%h/%h/%h exp=%h/%h/%h",
               req, dev_irq, ipi_irq, tmr_irq, exp_dev(), ipi_m, tmr_m);
    end
  endtask

  task automatic check_read(input int a, input string req);
    reg_wr = 0;
    reg_addr = ADDR_W'(a);
    #0.5;
    checks++;
    if (reg_rdata !== exp_read(a)) begin
      errors++;
      $display("FAIL %s read addr %0d act=%h exp=%h", req, a, reg_rdata, exp_read(a));
    end
  endtask

  // inputs are set at a falling edge; this applies them for one rising edge
  task automatic cycle(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
    check_out(req);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 16; a++) check_read(a, req);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog act=%0d cycles exp=completion", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    raw_m = '0; ipi_m = '0; tmr_m = '0;
    for (int c = 0; c < NCPU; c++) mask_m[c] = '0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_out("R1 during reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_out("R1 after reset");
    read_all("R1");

    // R2 extreme indices
    @(negedge clk); dev_post = 1; dev_post_idx = 6'd0; cycle("R2 idx0");
    dev_post = 1; dev_post_idx = 6'd63; cycle("R2 idx63");
    check_read(A_RAW, "R2 raw bits 0 and 63");

    // R4 mask write and R5 pending
    reg_wr = 1; reg_addr = 4'd3; reg_wdata = 64'h8000_0000_0000_0000; cycle("R4 mask3 msb");
    check_read(3, "R4 readback");
    check_read(NCPU + 3, "R5 pending cpu3");
    reg_wr = 1; reg_addr = 4'd1; reg_wdata = 64'hFFFF_FFFF_FFFF_FFFE; cycle("R5 mask1 no hit bit0");
    check_read(NCPU + 1, "R5 pending cpu1");

    // R3 post wins on same index, different indices both act
    dev_post = 1; dev_clr = 1; dev_post_idx = 6'd63; dev_clr_idx = 6'd63; cycle("R3 same idx post wins");
    check_read(A_RAW, "R3 same idx");
    dev_post = 1; dev_post_idx = 6'd5; dev_clr = 1; dev_clr_idx = 6'd0; cycle("R3 different idx");
    check_read(A_RAW, "R3 different idx");
    dev_clr = 1; dev_clr_idx = 6'd63; cycle("R3 clear 63 drops cpu3");

    // R6 / R7 IPI
    ipi_req = 4'b1010; cycle("R6 ipi set");
    check_read(A_IPI, "R6 ipi status");
    ipi_req = 4'b0010; ipi_clr = 4'b0011; cycle("R7 request wins on cpu1");
    check_read(A_IPI, "R7 ipi status");

    // R8 timer
    timer_tick = 1; cycle("R8 tick sets all");
    tmr_clr = 4'b0101; cycle("R8 clear");
    timer_tick = 1; tmr_clr = 4'b1111; cycle("R8 tick wins");
    check_read(A_TMR, "R8 timer status");

    // R9 writes to read-only and unmapped addresses
    for (int a = NCPU; a < 16; a++) begin
      reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = '1; cycle("R9 ro write");
    end
    read_all("R9 after ro writes");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      dev_post     = ($urandom % 3) == 0;
      dev_post_idx = 6'($urandom);
      dev_clr      = ($urandom % 3) == 0;
      dev_clr_idx  = (($urandom % 4) == 0) ? dev_post_idx : 6'($urandom);
      timer_tick   = ($urandom % 8) == 0;
      ipi_req      = NCPU'($urandom) & NCPU'($urandom);
      ipi_clr      = NCPU'($urandom);
      tmr_clr      = NCPU'($urandom);
      reg_wr       = ($urandom % 4) == 0;
      reg_addr     = ADDR_W'($urandom);
      reg_wdata    = {$urandom, $urandom} & {$urandom, $urandom};
      cycle("R2 R3 R4 R6 R7 R8 random");
      check_read(int'($urandom % 16), "R5 R9 random read");
    end
    read_all("R5 final");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule